// File: doc/BRIEF.md
# Absolute-Address Bus Cycle Sequencer

This block plays out the bus cycles of one absolute-addressed instruction on a byte-wide memory bus. The front end has already fetched and decoded the opcode and moved the program counter past it. It then pulses `start` with an access class and a width flag. The sequencer fetches the two operand bytes and builds the 16-bit data address from them. It then moves the data bytes in the exact order that class requires, including any dummy cycles. It also pulses `op_fire` at the point where the external operation unit must act. The last step is a one-cycle `done` pulse.

The program counter and stack pointer are loaded from `pc_in` and `sp_in` when a start is accepted. Their updated values appear on `pc_out` and `sp_out`. The two-byte data buffer is visible on `data_buf`. Exactly one bus access happens per busy cycle. During a read cycle, `bus_rdata` is sampled at the end of that cycle. During the `op_fire` cycle, the operation unit returns its result on `op_result` combinationally. For write and read-modify-write classes, that result is the data stored in the same cycle and is also loaded into the buffer.

Top module: `abs_bus_sequencer`

## Requirements
- R1: After reset, `bus_rd`, `bus_wr`, `done` and `op_fire` are low, and `pc_out` and `sp_out` are 0. No bus access occurs while the block is idle.
- R2: The first two cycles of every sequence read at P and P+1, where P is the accepted `pc_in`. Each of these reads advances the program counter. The data address A is {second byte, first byte}.
- R3: Class code 0 (read) reads A into the buffer low byte. With `wide`=1 it then reads A+1 into the high byte. In the following cycle `op_fire` and `done` are both high, and `pc_out` ends at P+2.
- R4: Class code 1 (write) stores `op_result[7:0]` at A with `op_fire` high in that same cycle. With `wide`=1 it then stores the captured `op_result[15:8]` at A+1. The buffer holds `op_result` afterwards.
- R5: Class code 2 (read-modify-write) with `wide`=1 makes these accesses in order:
  - read A;
  - read A+1;
  - read A+1 again as a dummy;
  - write `op_result[15:8]` at A+1, with `op_fire` high;
  - write `op_result[7:0]` at A.
- R6: Class code 2 with `wide`=0 makes these accesses in order:
  - read A;
  - write the byte just read back to A, unchanged;
  - write `op_result[7:0]` at A, with `op_fire` high.
- R7: Class code 3 (jump) has no data cycle. `op_fire` and `done` are high in the third cycle, and `pc_out` then equals A.
- R8: Class code 4 (subroutine call) makes these cycles in order:
  - one discarded read at P+2, without incrementing;
  - write (P+1)[15:8] at S, with `op_fire` high;
  - write (P+1)[7:0] at S-1.
  S is the accepted `sp_in`. Afterwards `sp_out` is S-2 and `pc_out` is A.
- R9: `done` is high for exactly one cycle, the cycle after the last bus access, and that cycle carries no bus access. `op_fire` is high in exactly one cycle per sequence. `bus_rd` and `bus_wr` are never high together.
- R10: A `start` that arrives while a sequence is in progress is ignored. The class, width, program counter and stack pointer of the running sequence are unchanged.
- R11: Class codes 5, 6 and 7 behave exactly like class code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (accepted only when idle) |
| acc_class | input | 3 | 0 read, 1 write, 2 read-modify-write, 3 jump, 4 subroutine call, 5-7 read |
| wide | input | 1 | 1 = 16-bit data, 0 = 8-bit data |
| pc_in | input | 16 | Program counter, pointing just past the opcode |
| sp_in | input | 16 | Stack pointer at start |
| op_result | input | 16 | Result from the operation unit, valid in the `op_fire` cycle |
| bus_rdata | input | 8 | Read data for the current cycle |
| bus_addr | output | 16 | Bus address |
| bus_rd | output | 1 | Read cycle |
| bus_wr | output | 1 | Write cycle |
| bus_wdata | output | 8 | Write data |
| op_fire | output | 1 | Perform strobe to the operation unit |
| done | output | 1 | One-cycle end-of-sequence pulse |
| pc_out | output | 16 | Current program counter |
| sp_out | output | 16 | Current stack pointer |
| data_buf | output | 16 | Data buffer, high byte in [15:8] |

## Verification
Cycle 0 of a sequence is the cycle right after the clock edge that accepts `start`. From there, each step's access, address, write data, `op_fire` and `done` are due in a fixed cycle index that depends only on the class and the width. The bench builds that per-cycle trace before launching the sequence and compares the outputs at every falling edge from cycle 0 up to and including the `done` cycle. One falling edge later it compares `pc_out`, `sp_out` and `data_buf`, because these registers settle on the edge that closes the `done` cycle. A start pulse raised in cycle 1 of a running sequence must leave that trace and the final state untouched.

// File: rtl/abs_seq_pkg.sv
package abs_seq_pkg;

   localparam logic [2:0] CLS_READ  = 3'd0;
   localparam logic [2:0] CLS_WRITE = 3'd1;
   localparam logic [2:0] CLS_RMW   = 3'd2;
   localparam logic [2:0] CLS_JMP   = 3'd3;
   localparam logic [2:0] CLS_JSR   = 3'd4;

   typedef enum logic [3:0] {
      ST_OPL,        // operand low from PC, PC++
      ST_OPH,        // operand high from PC, PC++, form data address
      ST_RD_LO_INC,  // read data low, address++
      ST_RD_LO,      // read data low, address held
      ST_RD_HI,      // read data high
      ST_RD_DUMMY,   // reread, result dropped
      ST_WR_DUMMY,   // write back unmodified low byte
      ST_WR_LO_INC,  // write low, address++
      ST_WR_HI,      // write high
      ST_WR_HI_DEC,  // write high, address--
      ST_WR_LO,      // write low
      ST_DISCARD,    // read at PC without increment, dropped
      ST_PUSH_HI,    // push return high
      ST_PUSH_LO,    // push return low
      ST_FIN         // no bus access, end of sequence
   } step_kind_e;

   typedef struct packed {
      step_kind_e kind;
      logic       perf;
   } step_t;

   function automatic step_t step_lookup(input logic [2:0] cls, input logic wide,
                                         input logic [2:0] idx);
      step_t seq [8];
      for (int i = 0; i < 8; i++) seq[i] = '{ST_FIN, 1'b0};
      seq[0] = '{ST_OPL, 1'b0};
      seq[1] = '{ST_OPH, 1'b0};
      case (cls)
         CLS_WRITE: begin
            seq[2] = '{ST_WR_LO_INC, 1'b1};
            if (wide) seq[3] = '{ST_WR_HI, 1'b0};
         end
         CLS_RMW: begin
            if (wide) begin
               seq[2] = '{ST_RD_LO_INC, 1'b0};
               seq[3] = '{ST_RD_HI, 1'b0};
               seq[4] = '{ST_RD_DUMMY, 1'b0};
               seq[5] = '{ST_WR_HI_DEC, 1'b1};
               seq[6] = '{ST_WR_LO, 1'b0};
            end else begin
               seq[2] = '{ST_RD_LO, 1'b0};
               seq[3] = '{ST_WR_DUMMY, 1'b0};
               seq[4] = '{ST_WR_LO, 1'b1};
            end
         end
         CLS_JMP: seq[2] = '{ST_FIN, 1'b1};
         CLS_JSR: begin
            seq[2] = '{ST_DISCARD, 1'b0};
            seq[3] = '{ST_PUSH_HI, 1'b1};
            seq[4] = '{ST_PUSH_LO, 1'b0};
         end
         default: begin
            seq[2] = '{ST_RD_LO_INC, 1'b0};
            if (wide) begin
               seq[3] = '{ST_RD_HI, 1'b0};
               seq[4] = '{ST_FIN, 1'b1};
            end else begin
               seq[3] = '{ST_FIN, 1'b1};
            end
         end
      endcase
      return seq[idx];
   endfunction

endpackage

// File: rtl/abs_seq_program.sv
module abs_seq_program
   import abs_seq_pkg::*;
(
   input  logic [2:0] cls,
   input  logic       wide,
   input  logic [2:0] idx,
   output step_t      step
);
   always_comb step = step_lookup(cls, wide, idx);
endmodule

// File: rtl/abs_seq_regs.sv
module abs_seq_regs
   import abs_seq_pkg::*;
#(
   parameter int DW = 8,
   parameter int AW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [AW-1:0]   pc_in,
   input  logic [AW-1:0]   sp_in,
   input  logic            busy,
   input  step_t           step,
   input  logic            ld_result,
   input  logic            ld_pc,
   input  logic [DW-1:0]   bus_rdata,
   input  logic [2*DW-1:0] op_result,
   output logic [AW-1:0]   pc_q,
   output logic [AW-1:0]   sp_q,
   output logic [AW-1:0]   dadr_q,
   output logic [AW-1:0]   opr_q,
   output logic [AW-1:0]   ret_q,
   output logic [2*DW-1:0] buf_q
);
   localparam int LANES = 2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q   <= '0;
         sp_q   <= '0;
         dadr_q <= '0;
         opr_q  <= '0;
         ret_q  <= '0;
      end else if (load) begin
         pc_q <= pc_in;
         sp_q <= sp_in;
      end else if (busy) begin
         case (step.kind)
            ST_OPL: begin
               opr_q[DW-1:0] <= bus_rdata;
               pc_q          <= pc_q + 1'b1;
            end
            ST_OPH: begin
               opr_q[AW-1:DW] <= bus_rdata;
               dadr_q         <= {bus_rdata, opr_q[DW-1:0]};
               pc_q           <= pc_q + 1'b1;
            end
            ST_RD_LO_INC, ST_WR_LO_INC: dadr_q <= dadr_q + 1'b1;
            ST_WR_HI_DEC:               dadr_q <= dadr_q - 1'b1;
            ST_DISCARD:                 ret_q  <= pc_q - 1'b1;
            ST_PUSH_HI, ST_PUSH_LO:     sp_q   <= sp_q - 1'b1;
            default: ;
         endcase
         if (ld_pc) pc_q <= opr_q;
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic          from_bus;
      logic [DW-1:0] lane_q;
      if (l == 0) begin : g_lo
         assign from_bus = (step.kind == ST_RD_LO_INC) || (step.kind == ST_RD_LO);
      end else begin : g_hi
         assign from_bus = (step.kind == ST_RD_HI);
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 lane_q <= '0;
         else if (busy && ld_result) lane_q <= op_result[l*DW +: DW];
         else if (busy && from_bus)  lane_q <= bus_rdata;
      end
      assign buf_q[l*DW +: DW] = lane_q;
   end

   AST_ADDR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !load && step.kind == ST_OPH) |=> dadr_q == {$past(bus_rdata), $past(opr_q[DW-1:0])}); // R2
   AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !load && (step.kind == ST_PUSH_HI || step.kind == ST_PUSH_LO)) |=> sp_q == $past(sp_q) - 1'b1); // R8
endmodule

// File: rtl/abs_bus_sequencer.sv
module abs_bus_sequencer
   import abs_seq_pkg::*;
#(
   parameter int DW = 8,
   parameter int AW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [2:0]      acc_class,
   input  logic            wide,
   input  logic [AW-1:0]   pc_in,
   input  logic [AW-1:0]   sp_in,
   input  logic [2*DW-1:0] op_result,
   input  logic [DW-1:0]   bus_rdata,
   output logic [AW-1:0]   bus_addr,
   output logic            bus_rd,
   output logic            bus_wr,
   output logic [DW-1:0]   bus_wdata,
   output logic            op_fire,
   output logic            done,
   output logic [AW-1:0]   pc_out,
   output logic [AW-1:0]   sp_out,
   output logic [2*DW-1:0] data_buf
);
   localparam int IDXW = 3;

   if (AW != 2 * DW) begin : g_bad_width
      $error("abs_bus_sequencer: AW must equal two data bytes");
   end

   logic            busy_q, wide_q, load;
   logic [2:0]      cls_q;
   logic [IDXW-1:0] idx_q;
   step_t           cur;
   logic            ld_result, ld_pc, hi_lane;
   logic [AW-1:0]   pc_q, sp_q, dadr_q, opr_q, ret_q;
   logic [2*DW-1:0] buf_q;

   assign load = start && !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         cls_q  <= CLS_READ;
         wide_q <= 1'b0;
      end else if (load) begin
         busy_q <= 1'b1;
         idx_q  <= '0;
         cls_q  <= (acc_class > CLS_JSR) ? CLS_READ : acc_class;
         wide_q <= wide;
      end else if (busy_q) begin
         if (cur.kind == ST_FIN) busy_q <= 1'b0;
         else                    idx_q  <= idx_q + 1'b1;
      end
   end

   abs_seq_program u_prog (
      .cls  (cls_q),
      .wide (wide_q),
      .idx  (idx_q),
      .step (cur)
   );

   assign op_fire   = busy_q && cur.perf;
   assign done      = busy_q && (cur.kind == ST_FIN);
   assign ld_result = op_fire && (cls_q == CLS_WRITE || cls_q == CLS_RMW);
   assign ld_pc     = op_fire && (cls_q == CLS_JMP || cls_q == CLS_JSR);
   assign hi_lane   = (cur.kind == ST_WR_HI) || (cur.kind == ST_WR_HI_DEC);

   abs_seq_regs #(.DW(DW), .AW(AW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .pc_in     (pc_in),
      .sp_in     (sp_in),
      .busy      (busy_q),
      .step      (cur),
      .ld_result (ld_result),
      .ld_pc     (ld_pc),
      .bus_rdata (bus_rdata),
      .op_result (op_result),
      .pc_q      (pc_q),
      .sp_q      (sp_q),
      .dadr_q    (dadr_q),
      .opr_q     (opr_q),
      .ret_q     (ret_q),
      .buf_q     (buf_q)
   );

   always_comb begin
      bus_rd    = 1'b0;
      bus_wr    = 1'b0;
      bus_addr  = pc_q;
      bus_wdata = '0;
      if (busy_q) begin
         case (cur.kind)
            ST_OPL, ST_OPH, ST_DISCARD: bus_rd = 1'b1;
            ST_RD_LO_INC, ST_RD_LO, ST_RD_HI, ST_RD_DUMMY: begin
               bus_rd   = 1'b1;
               bus_addr = dadr_q;
            end
            ST_WR_DUMMY, ST_WR_LO_INC, ST_WR_HI, ST_WR_HI_DEC, ST_WR_LO: begin
               bus_wr   = 1'b1;
               bus_addr = dadr_q;
               if (cur.perf) bus_wdata = hi_lane ? op_result[2*DW-1:DW] : op_result[DW-1:0];
               else          bus_wdata = hi_lane ? buf_q[2*DW-1:DW] : buf_q[DW-1:0];
            end
            ST_PUSH_HI: begin
               bus_wr    = 1'b1;
               bus_addr  = sp_q;
               bus_wdata = ret_q[AW-1:DW];
            end
            ST_PUSH_LO: begin
               bus_wr    = 1'b1;
               bus_addr  = sp_q;
               bus_wdata = ret_q[DW-1:0];
            end
            default: ;
         endcase
      end
   end

   assign pc_out   = pc_q;
   assign sp_out   = sp_q;
   assign data_buf = buf_q;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !(bus_rd || bus_wr)); // R1
   AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr)); // R9
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_FIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      op_fire |=> !op_fire); // R9
   AST_HOLD_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !done) |=> (busy_q && $stable(cls_q) && $stable(wide_q))); // R10
   AST_JMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (op_fire && cls_q == CLS_JMP) |=> pc_out == $past(opr_q)); // R7
endmodule

// File: tb/abs_bus_sequencer_tb_top.sv
module abs_bus_sequencer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  acc_class = '0;
   logic        wide = 1'b0;
   logic [15:0] pc_in = '0, sp_in = '0, op_result = '0;
   logic [7:0]  bus_rdata;
   logic [15:0] bus_addr, pc_out, sp_out, data_buf;
   logic        bus_rd, bus_wr, op_fire, done;
   logic [7:0]  bus_wdata;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   function automatic logic [7:0] mem_f(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h3C;
   endfunction

   assign bus_rdata = mem_f(bus_addr);

   abs_bus_sequencer dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .acc_class(acc_class), .wide(wide),
      .pc_in(pc_in), .sp_in(sp_in), .op_result(op_result), .bus_rdata(bus_rdata),
      .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .op_fire(op_fire), .done(done), .pc_out(pc_out), .sp_out(sp_out), .data_buf(data_buf)
   );

   logic        e_rd [8];
   logic        e_wr [8];
   logic        e_fire [8];
   logic [15:0] e_addr [8];
   logic [7:0]  e_dat [8];
   int          e_len;
   logic [15:0] e_pc, e_sp, e_buf, e_bmask;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   task automatic add(input logic rd, input logic wr, input logic [15:0] a,
                      input logic [7:0] d, input logic f);
      e_rd[e_len] = rd; e_wr[e_len] = wr; e_addr[e_len] = a;
      e_dat[e_len] = d; e_fire[e_len] = f;
      e_len++;
   endtask

   task automatic build(input logic [2:0] c, input bit w, input logic [15:0] p,
                        input logic [15:0] s, input logic [15:0] r);
      logic [15:0] a, ret;
      a = {mem_f(p + 16'd1), mem_f(p)};
      ret = p + 16'd1;
      e_len = 0; e_pc = p + 16'd2; e_sp = s; e_buf = '0; e_bmask = '0;
      add(1, 0, p, 8'h00, 0);
      add(1, 0, p + 16'd1, 8'h00, 0);
      case (c)
         3'd1: begin
            add(0, 1, a, r[7:0], 1);
            if (w) add(0, 1, a + 16'd1, r[15:8], 0);
            add(0, 0, 16'h0, 8'h00, 0);
            e_buf = r; e_bmask = 16'hFFFF;
         end
         3'd2: begin
            if (w) begin
               add(1, 0, a, 8'h00, 0);
               add(1, 0, a + 16'd1, 8'h00, 0);
               add(1, 0, a + 16'd1, 8'h00, 0);
               add(0, 1, a + 16'd1, r[15:8], 1);
               add(0, 1, a, r[7:0], 0);
            end else begin
               add(1, 0, a, 8'h00, 0);
               add(0, 1, a, mem_f(a), 0);
               add(0, 1, a, r[7:0], 1);
            end
            add(0, 0, 16'h0, 8'h00, 0);
            e_buf = r; e_bmask = 16'hFFFF;
         end
         3'd3: begin
            add(0, 0, 16'h0, 8'h00, 1);
            e_pc = a;
         end
         3'd4: begin
            add(1, 0, p + 16'd2, 8'h00, 0);
            add(0, 1, s, ret[15:8], 1);
            add(0, 1, s - 16'd1, ret[7:0], 0);
            add(0, 0, 16'h0, 8'h00, 0);
            e_pc = a; e_sp = s - 16'd2;
         end
         default: begin
            add(1, 0, a, 8'h00, 0);
            if (w) add(1, 0, a + 16'd1, 8'h00, 0);
            add(0, 0, 16'h0, 8'h00, 1);
            e_buf = {mem_f(a + 16'd1), mem_f(a)};
            e_bmask = w ? 16'hFFFF : 16'h00FF;
         end
      endcase
   endtask

   function automatic string req_of(input logic [2:0] c, input bit w);
      case (c)
         3'd0: return "R3";
         3'd1: return "R4";
         3'd2: return w ? "R5" : "R6";
         3'd3: return "R7";
         3'd4: return "R8";
         default: return "R11";
      endcase
   endfunction

   task automatic run_seq(input logic [2:0] c, input bit w, input logic [15:0] p,
                          input logic [15:0] s, input logic [15:0] r, input bit poke);
      string rq;
      logic [31:0] act, expv;
      rq = req_of(c, w);
      build(c, w, p, s, r);
      @(negedge clk);
      start = 1'b1; acc_class = c; wide = w; pc_in = p; sp_in = s; op_result = r;
      for (int k = 0; k < e_len; k++) begin
         @(negedge clk);
         if (k == 0) start = 1'b0;
         act  = {bus_rd, bus_wr, op_fire, done, 4'h0,
                 (bus_rd || bus_wr) ? bus_addr : 16'h0, bus_wr ? bus_wdata : 8'h00};
         expv = {e_rd[k], e_wr[k], e_fire[k], (k == e_len - 1), 4'h0,
                 (e_rd[k] || e_wr[k]) ? e_addr[k] : 16'h0, e_wr[k] ? e_dat[k] : 8'h00};
         chk(act == expv, (k < 2) ? "R2" : ((k == e_len - 1) ? "R9" : rq),
             $sformatf("cycle %0d trace", k), act, expv);
         if (poke && k == 1) begin
            start = 1'b1; acc_class = ~c; wide = ~w; pc_in = ~p; sp_in = ~s;
         end
         if (poke && k == 2) begin
            start = 1'b0; pc_in = p; sp_in = s;
         end
      end
      @(negedge clk);
      chk(!bus_rd && !bus_wr && !done && !op_fire, "R9", "quiet after done",
          {28'h0, bus_rd, bus_wr, done, op_fire}, 32'h0);
      chk(pc_out == e_pc && sp_out == e_sp, poke ? "R10" : rq, "pc/sp after",
          {pc_out, sp_out}, {e_pc, e_sp});
      chk((data_buf & e_bmask) == (e_buf & e_bmask), rq, "data buffer",
          {16'h0, data_buf & e_bmask}, {16'h0, e_buf & e_bmask});
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!bus_rd && !bus_wr && !done && !op_fire && pc_out == 16'h0 && sp_out == 16'h0,
          "R1", "reset state", {pc_out, sp_out}, 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!bus_rd && !bus_wr && !done && !op_fire, "R1", "idle after reset",
          {28'h0, bus_rd, bus_wr, done, op_fire}, 32'h0);
      // directed corners: every class, both widths, wrap points
      for (int c = 0; c < 8; c++) begin
         run_seq(3'(c), 1'b0, 16'h1000, 16'h01FF, 16'hA55A, 1'b0);
         run_seq(3'(c), 1'b1, 16'hFFFE, 16'h0000, 16'h1234, 1'b0);
      end
      run_seq(3'd2, 1'b1, 16'hFFFF, 16'h0100, 16'hBEEF, 1'b1); // R10
      run_seq(3'd4, 1'b0, 16'h2000, 16'h01FF, 16'h0000, 1'b1); // R10
      for (int n = 0; n < 200; n++) begin
         run_seq(3'($urandom % 8), 1'($urandom % 2), 16'($urandom), 16'($urandom),
                 16'($urandom), ($urandom % 4) == 0);
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule